// File: doc/BRIEF.md
# Case-table dispatch unit

This unit carries out a two-step, table-driven case selection for a small 8-bit processor. The first step (prepare) fetches a case count and a 16-bit return address from the bytes that follow its opcode. It keeps the count in an internal counter and pushes the return address onto a stack in internal RAM. That stack grows toward lower addresses. The step then moves the stack pointer down by two and advances the program counter past its four-byte instruction.

The second step (dispatch) walks a table that starts right after its opcode. Each entry is three bytes: a key byte, then a target address with the low byte first. The unit compares each key with the accumulator value, and the first equal key selects that entry's target. When no key matches, it takes a default address stored right after the last entry. The result goes to the program counter, so the selected routine runs as a subroutine that returns to the address pushed by prepare. Dispatch always takes a fixed, count-dependent number of cycles, and it reports through the zero flag whether a key matched.

The surrounding core decodes the opcode and then pulses `start`, with `op_sel` choosing the step. It presents the opcode address, the accumulator value and the stack pointer, and applies the program counter, stack pointer and zero-flag updates on the `done` cycle.

Top module: `ctd_case_dispatch`

## Requirements
- R1: After reset, `done`, `pm_rd`, `stk_we`, `pc_we`, `r_we` and `z_we` are low, and the stored case count is 0. A dispatch issued before any prepare therefore takes the default address at opcode+1 (low byte) and opcode+2 (high byte).
- R2: Prepare (`op_sel`=0) reads the count byte at opcode+1, the return-address low byte at opcode+2 and the high byte at opcode+3, and reads nothing beyond opcode+3.
- R3: Prepare writes the return-address high byte to stack address R-1 and then the low byte to R-2, using 7-bit pointer arithmetic. On `done` it raises `r_we` with `r_next`=R-2, and raises `pc_we` with `pc_next`=opcode+4.
- R4: `done` is a single-cycle pulse. For prepare it is high in the 4th cycle after the clock edge that samples `start`.
- R5: Dispatch (`op_sel`=1) reads entry i as key at opcode+1+3i, target low at opcode+2+3i and target high at opcode+3+3i. The default target's low byte is at opcode+1+3d and its high byte at opcode+2+3d, where d is the stored count.
- R6: When one or more keys equal the accumulator value captured at `start`, `pc_next` on `done` is the target of the lowest-indexed matching entry, with `pc_we` high.
- R7: When no key matches, or d=0, `pc_next` on `done` is the default target.
- R8: Dispatch raises `done` exactly 5+7*d cycles after the edge that samples `start`, whether it matches early, late or never.
- R9: On dispatch `done`, `z_we` is high, and `z_out` is 1 when a key matched and 0 when the default was taken. Dispatch makes no stack write and does not raise `r_we`.
- R10: Once a key matches, no byte beyond that entry's target high byte is read.
- R11: `start` is ignored while an operation is in progress.
- R12: The count loaded by prepare stays in effect for any number of later dispatches, until the next prepare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| op_sel | input | 1 | 0 = prepare, 1 = dispatch |
| a_in | input | 8 | Accumulator value to match against |
| r_cur | input | 7 | Current stack pointer |
| pc_cur | input | 16 | Address of the opcode |
| pm_rd | output | 1 | Program memory read strobe |
| pm_addr | output | 16 | Program memory address |
| pm_data | input | 8 | Program memory data (combinational read) |
| stk_we | output | 1 | Stack RAM write enable |
| stk_addr | output | 7 | Stack RAM write address |
| stk_wdata | output | 8 | Stack RAM write data |
| done | output | 1 | Operation complete, single-cycle pulse |
| pc_we | output | 1 | Program counter update strobe |
| pc_next | output | 16 | New program counter |
| r_we | output | 1 | Stack pointer update strobe |
| r_next | output | 7 | New stack pointer |
| z_we | output | 1 | Zero flag update strobe |
| z_out | output | 1 | New zero flag value |

## Verification
The bench targets these corner cases:
- **Empty table.** A design that scans before checking d=0 would compare against the default bytes and could select a bogus target.
- **Duplicate keys.** A design that lets a later match overwrite an earlier one returns the wrong target.
- **Match in the final entry of a 255-entry table.** An off-by-one in the remaining-entry counter here either misses the match or reads the default bytes as a key.
- **Cycle count for first-entry, last-entry and missing matches.** Finishing as soon as the scan ends, instead of padding to the fixed budget, shows up as early completion.

It also holds `start` high through a whole dispatch, which a design that restarts mid-scan would fail. It tracks the highest program address read, so reading past a matched entry is caught.

// File: rtl/ctd_pkg.sv
package ctd_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_P_CNT,
      ST_P_LO,
      ST_P_HI,
      ST_P_FIN,
      ST_D_KEY,
      ST_D_LO,
      ST_D_HI,
      ST_D_DFL_LO,
      ST_D_DFL_HI,
      ST_D_WAIT
   } ctd_state_e;

   typedef enum logic {
      OP_PREP = 1'b0,
      OP_DISP = 1'b1
   } ctd_op_e;

   function automatic logic [15:0] join_le(input logic [7:0] lo, input logic [7:0] hi);
      return {hi, lo};
   endfunction

endpackage

// File: rtl/ctd_timer.sv
module ctd_timer #(
   parameter int DW       = 8,
   parameter int CYC_BASE = 5,
   parameter int CYC_PER  = 7,
   parameter int CW       = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [DW-1:0] count_i,
   input  logic          run_i,
   output logic          expire_o
);

   localparam bit PER_POW2 = (CYC_PER & (CYC_PER - 1)) == 0;

   logic [CW-1:0] lim_d, lim_q, cnt_q;
   logic [CW-1:0] scaled;

   generate
      if (PER_POW2) begin : g_shift
         assign scaled = CW'(count_i) << $clog2(CYC_PER);
      end else begin : g_mult
         assign scaled = CW'(count_i) * CW'(CYC_PER);
      end
   endgenerate

   assign lim_d = scaled + CW'(CYC_BASE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q <= '0;
         cnt_q <= '0;
      end else if (load_i) begin
         lim_q <= lim_d;
         cnt_q <= CW'(1);
      end else if (run_i) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign expire_o = run_i && (cnt_q == lim_q);

   AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (cnt_q <= lim_q)); // R8

endmodule

// File: rtl/ctd_stack_port.sv
module ctd_stack_port #(
   parameter int            RW    = 7,
   parameter int            DW    = 8,
   parameter logic [RW-1:0] TOP   = 7'h5B,
   parameter logic [RW-1:0] FLOOR = 7'h0C
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [RW-1:0] r_base_i,
   input  logic          wr_hi_i,
   input  logic          wr_lo_i,
   input  logic [DW-1:0] hi_i,
   input  logic [DW-1:0] lo_i,
   output logic          stk_we_o,
   output logic [RW-1:0] stk_addr_o,
   output logic [DW-1:0] stk_wdata_o,
   output logic [RW-1:0] r_dec_o
);

   assign stk_we_o    = wr_hi_i | wr_lo_i;
   assign stk_addr_o  = wr_lo_i ? (r_base_i - RW'(2)) : (r_base_i - RW'(1));
   assign stk_wdata_o = wr_lo_i ? lo_i : hi_i;
   assign r_dec_o     = r_base_i - RW'(2);

   AST_PUSH_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_we_o && $past(stk_we_o)) |-> (stk_addr_o == $past(stk_addr_o) - RW'(1))); // R3

   AST_STACK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      stk_we_o |-> ((stk_addr_o >= FLOOR) && (stk_addr_o < TOP))); // R3

endmodule

// File: rtl/ctd_case_dispatch.sv
module ctd_case_dispatch
   import ctd_pkg::*;
#(
   parameter int            AW        = 16,
   parameter int            DW        = 8,
   parameter int            RW        = 7,
   parameter int            CYC_BASE  = 5,
   parameter int            CYC_PER   = 7,
   parameter logic [RW-1:0] STK_TOP   = 7'h5B,
   parameter logic [RW-1:0] STK_FLOOR = 7'h0C
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          op_sel,
   input  logic [DW-1:0] a_in,
   input  logic [RW-1:0] r_cur,
   input  logic [AW-1:0] pc_cur,
   output logic          pm_rd,
   output logic [AW-1:0] pm_addr,
   input  logic [DW-1:0] pm_data,
   output logic          stk_we,
   output logic [RW-1:0] stk_addr,
   output logic [DW-1:0] stk_wdata,
   output logic          done,
   output logic          pc_we,
   output logic [AW-1:0] pc_next,
   output logic          r_we,
   output logic [RW-1:0] r_next,
   output logic          z_we,
   output logic          z_out
);

   localparam int ADDR_BYTES = AW / DW;
   localparam int ENT_LEN    = 1 + ADDR_BYTES;
   localparam int PREP_LEN   = 2 + ADDR_BYTES;
   localparam int CW         = $clog2(CYC_BASE + CYC_PER * ((1 << DW) - 1) + 1);

   generate
      if (AW != 2 * DW) begin : g_bad_aw
         $error("ctd_case_dispatch: address must be exactly two data bytes");
      end
      if (CYC_BASE < 3) begin : g_bad_base
         $error("ctd_case_dispatch: CYC_BASE too small for default fetch");
      end
      if (CYC_PER < 3) begin : g_bad_per
         $error("ctd_case_dispatch: CYC_PER too small for entry fetch");
      end
      if (STK_FLOOR >= STK_TOP) begin : g_bad_stk
         $error("ctd_case_dispatch: stack window empty");
      end
   endgenerate

   ctd_state_e    state_q;
   logic [AW-1:0] base_q, ptr_q, tgt_q;
   logic [DW-1:0] a_q, cnt_q, left_q, lo_q;
   logic [RW-1:0] r_q;
   logic          hit_q;

   logic idle, accept, in_disp, expire;

   assign idle    = (state_q == ST_IDLE);
   assign accept  = idle && start;
   assign in_disp = (state_q == ST_D_KEY)    || (state_q == ST_D_LO)     ||
                    (state_q == ST_D_HI)     || (state_q == ST_D_DFL_LO) ||
                    (state_q == ST_D_DFL_HI) || (state_q == ST_D_WAIT);

   ctd_timer #(
      .DW(DW), .CYC_BASE(CYC_BASE), .CYC_PER(CYC_PER), .CW(CW)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (accept && (op_sel == OP_DISP)),
      .count_i  (cnt_q),
      .run_i    (in_disp),
      .expire_o (expire)
   );

   // Sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         base_q  <= '0;
         ptr_q   <= '0;
         tgt_q   <= '0;
         a_q     <= '0;
         cnt_q   <= '0;
         left_q  <= '0;
         lo_q    <= '0;
         r_q     <= '0;
         hit_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  base_q <= pc_cur;
                  ptr_q  <= pc_cur + AW'(1);
                  a_q    <= a_in;
                  r_q    <= r_cur;
                  left_q <= cnt_q;
                  if (op_sel == OP_PREP)
                     state_q <= ST_P_CNT;
                  else if (cnt_q == '0)
                     state_q <= ST_D_DFL_LO;
                  else
                     state_q <= ST_D_KEY;
               end
            end
            ST_P_CNT: begin
               cnt_q   <= pm_data;
               ptr_q   <= ptr_q + AW'(1);
               state_q <= ST_P_LO;
            end
            ST_P_LO: begin
               lo_q    <= pm_data;
               ptr_q   <= ptr_q + AW'(1);
               state_q <= ST_P_HI;
            end
            ST_P_HI:  state_q <= ST_P_FIN;
            ST_P_FIN: state_q <= ST_IDLE;
            ST_D_KEY: begin
               if (pm_data == a_q) begin
                  ptr_q   <= ptr_q + AW'(1);
                  state_q <= ST_D_LO;
               end else begin
                  ptr_q   <= ptr_q + AW'(ENT_LEN);
                  left_q  <= left_q - DW'(1);
                  state_q <= (left_q == DW'(1)) ? ST_D_DFL_LO : ST_D_KEY;
               end
            end
            ST_D_LO: begin
               lo_q    <= pm_data;
               ptr_q   <= ptr_q + AW'(1);
               state_q <= ST_D_HI;
            end
            ST_D_HI: begin
               tgt_q   <= join_le(lo_q, pm_data);
               hit_q   <= 1'b1;
               state_q <= ST_D_WAIT;
            end
            ST_D_DFL_LO: begin
               lo_q    <= pm_data;
               ptr_q   <= ptr_q + AW'(1);
               state_q <= ST_D_DFL_HI;
            end
            ST_D_DFL_HI: begin
               tgt_q   <= join_le(lo_q, pm_data);
               hit_q   <= 1'b0;
               state_q <= ST_D_WAIT;
            end
            ST_D_WAIT: begin
               if (expire) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // Program memory read port
   always_comb begin
      case (state_q)
         ST_P_CNT, ST_P_LO, ST_P_HI,
         ST_D_KEY, ST_D_LO, ST_D_HI,
         ST_D_DFL_LO, ST_D_DFL_HI: pm_rd = 1'b1;
         default:                  pm_rd = 1'b0;
      endcase
   end
   assign pm_addr = ptr_q;

   ctd_stack_port #(
      .RW(RW), .DW(DW), .TOP(STK_TOP), .FLOOR(STK_FLOOR)
   ) i_stack (
      .clk         (clk),
      .rst_n       (rst_n),
      .r_base_i    (r_q),
      .wr_hi_i     (state_q == ST_P_HI),
      .wr_lo_i     (state_q == ST_P_FIN),
      .hi_i        (pm_data),
      .lo_i        (lo_q),
      .stk_we_o    (stk_we),
      .stk_addr_o  (stk_addr),
      .stk_wdata_o (stk_wdata),
      .r_dec_o     (r_next)
   );

   // Completion and architectural updates
   assign done    = (state_q == ST_P_FIN) || ((state_q == ST_D_WAIT) && expire);
   assign pc_we   = done;
   assign pc_next = (state_q == ST_P_FIN) ? (base_q + AW'(PREP_LEN)) : tgt_q;
   assign r_we    = (state_q == ST_P_FIN);
   assign z_we    = (state_q == ST_D_WAIT) && expire;
   assign z_out   = hit_q;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R4

   AST_SCAN_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_rd && $past(pm_rd)) |->
         (((pm_addr - $past(pm_addr)) == AW'(1)) ||
          ((pm_addr - $past(pm_addr)) == AW'(ENT_LEN)))); // R5

   AST_DISP_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      in_disp |-> (!stk_we && !r_we)); // R9

   AST_ZFLAG_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      z_we |=> (idle && !pm_rd)); // R9

endmodule

// File: tb/test_ctd_case_dispatch.sv
module test_ctd_case_dispatch;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        op_sel = 1'b0;
   logic [7:0]  a_in = '0;
   logic [6:0]  r_cur = '0;
   logic [15:0] pc_cur = '0;
   logic        pm_rd;
   logic [15:0] pm_addr;
   logic [7:0]  pm_data;
   logic        stk_we;
   logic [6:0]  stk_addr;
   logic [7:0]  stk_wdata;
   logic        done, pc_we, r_we, z_we, z_out;
   logic [15:0] pc_next;
   logic [6:0]  r_next;

   logic [7:0] mem [0:65535];
   logic [7:0] stk [0:127];

   int checks = 0;
   int errors = 0;
   logic [7:0] d_model = 8'd0;

   // results of the last operation
   int          cyc, max_off, nwr;
   bit          got_done, s_pcwe, s_rwe, s_zwe, s_z;
   logic [15:0] s_pc;
   logic [6:0]  s_r;

   always #4 clk = ~clk;

   assign pm_data = mem[pm_addr];

   ctd_case_dispatch i_ctd_case_dispatch (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
      .a_in(a_in), .r_cur(r_cur), .pc_cur(pc_cur),
      .pm_rd(pm_rd), .pm_addr(pm_addr), .pm_data(pm_data),
      .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
      .done(done), .pc_we(pc_we), .pc_next(pc_next),
      .r_we(r_we), .r_next(r_next), .z_we(z_we), .z_out(z_out)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input bit op, input logic [15:0] pc, input logic [7:0] a,
                         input logic [6:0] r, input bit hold);
      logic [15:0] off;
      @(negedge clk);
      start = 1'b1; op_sel = op; pc_cur = pc; a_in = a; r_cur = r;
      @(posedge clk);
      cyc = 0; max_off = -1; nwr = 0; got_done = 0;
      while (!got_done && cyc < 3000) begin
         @(negedge clk);
         cyc++;
         if (!hold) start = 1'b0;
         else begin
            op_sel = ~op_sel; pc_cur = pc_cur + 16'h0100; a_in = ~a_in; r_cur = 7'h20;
         end
         if (pm_rd) begin
            off = pm_addr - pc;
            if (int'(off) > max_off) max_off = int'(off);
         end
         if (stk_we) begin
            stk[stk_addr] = stk_wdata;
            nwr++;
         end
         if (done) begin
            got_done = 1; s_pcwe = pc_we; s_pc = pc_next; s_rwe = r_we;
            s_r = r_next; s_zwe = z_we; s_z = z_out;
            start = 1'b0;
         end
      end
   endtask

   task automatic do_prep(input logic [15:0] pc, input logic [7:0] k,
                          input logic [15:0] ret, input logic [6:0] r);
      mem[pc] = 8'h7A; mem[pc + 16'd1] = k;
      mem[pc + 16'd2] = ret[7:0]; mem[pc + 16'd3] = ret[15:8];
      stk[r - 7'd1] = ~ret[15:8]; stk[r - 7'd2] = ~ret[7:0];
      run_op(1'b0, pc, 8'h00, r, 1'b0);
      chk(got_done && cyc == 4, "R4", "prepare done cycle", cyc, 4);
      chk(max_off == 3, "R2", "prepare last read offset", max_off, 3);
      chk(nwr == 2 && stk[r - 7'd1] == ret[15:8], "R3", "stack R-1 high byte",
          int'(stk[r - 7'd1]), int'(ret[15:8]));
      chk(stk[r - 7'd2] == ret[7:0], "R3", "stack R-2 low byte",
          int'(stk[r - 7'd2]), int'(ret[7:0]));
      chk(s_rwe && s_r == r - 7'd2, "R3", "stack pointer update", int'(s_r), int'(r - 7'd2));
      chk(s_pcwe && s_pc == pc + 16'd4, "R3", "pc after prepare", int'(s_pc), int'(pc + 16'd4));
      d_model = k;
   endtask

   // mode 0: no key matches, 1: single match at h, 2: matches at h and later
   task automatic build_table(input logic [15:0] pc, input logic [7:0] k,
                              input logic [7:0] a, input int mode, input int h);
      mem[pc] = 8'h69;
      for (int i = 0; i < int'(k); i++) begin
         logic [7:0] key;
         key = 8'($urandom);
         if (key == a) key = key ^ 8'h01;
         if (mode != 0 && i == h) key = a;
         if (mode == 2 && i > h && (i % 2) == 1) key = a;
         mem[pc + 16'(1 + 3 * i)] = key;
         mem[pc + 16'(2 + 3 * i)] = 8'($urandom);
         mem[pc + 16'(3 + 3 * i)] = 8'($urandom);
      end
      mem[pc + 16'(1 + 3 * int'(k))] = 8'($urandom);
      mem[pc + 16'(2 + 3 * int'(k))] = 8'($urandom);
   endtask

   task automatic do_disp(input logic [15:0] pc, input logic [7:0] a, input bit hold,
                          input string tag);
      int hit, exp_off, exp_cyc;
      logic [15:0] exp_pc;
      hit = -1;
      for (int i = 0; i < int'(d_model); i++)
         if (hit < 0 && mem[pc + 16'(1 + 3 * i)] == a) hit = i;
      if (hit >= 0) begin
         exp_pc  = {mem[pc + 16'(3 + 3 * hit)], mem[pc + 16'(2 + 3 * hit)]};
         exp_off = 3 * hit + 3;
      end else begin
         exp_pc  = {mem[pc + 16'(2 + 3 * int'(d_model))], mem[pc + 16'(1 + 3 * int'(d_model))]};
         exp_off = 3 * int'(d_model) + 2;
      end
      exp_cyc = 5 + 7 * int'(d_model);
      run_op(1'b1, pc, a, 7'h40, hold);
      chk(got_done && cyc == exp_cyc, "R8", {tag, " dispatch cycles"}, cyc, exp_cyc);
      chk(s_pcwe && s_pc == exp_pc, (hit >= 0) ? "R6" : "R7", {tag, " target"},
          int'(s_pc), int'(exp_pc));
      chk(s_zwe && s_z == (hit >= 0), "R9", {tag, " zero flag"}, int'(s_z), int'(hit >= 0));
      chk(nwr == 0 && !s_rwe, "R9", {tag, " no stack activity"}, nwr, 0);
      chk(max_off == exp_off, (hit >= 0) ? "R10" : "R5", {tag, " last read offset"},
          max_off, exp_off);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd5150));
      for (int i = 0; i < 128; i++) stk[i] = 8'h00;
      // R1 reset state
      repeat (3) @(negedge clk);
      chk(!done && !pm_rd && !stk_we && !pc_we && !r_we && !z_we, "R1",
          "outputs during reset", int'({done, pm_rd, stk_we, pc_we, r_we, z_we}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && !pm_rd && !stk_we && !pc_we && !r_we && !z_we, "R1",
          "outputs after reset", int'({done, pm_rd, stk_we, pc_we, r_we, z_we}), 0);
      // R1 count is zero: default right after opcode
      build_table(16'h0800, 8'd0, 8'h55, 0, 0);
      do_disp(16'h0800, 8'h55, 1'b0, "R1 empty after reset");

      // directed prepare / dispatch, R12 count retained across dispatches
      do_prep(16'h1000, 8'd3, 16'hBEEF, 7'h5B);
      build_table(16'h2000, 8'd3, 8'h42, 1, 0);
      do_disp(16'h2000, 8'h42, 1'b0, "R6 first entry");
      build_table(16'h2100, 8'd3, 8'h42, 1, 2);
      do_disp(16'h2100, 8'h42, 1'b0, "R12 last entry");
      build_table(16'h2200, 8'd3, 8'h42, 0, 0);
      do_disp(16'h2200, 8'h42, 1'b0, "R7 no match");
      build_table(16'h2300, 8'd3, 8'h42, 2, 0);
      do_disp(16'h2300, 8'h42, 1'b0, "R6 duplicate keys");
      // R11 start held high during dispatch
      build_table(16'h2400, 8'd3, 8'h17, 1, 1);
      do_disp(16'h2400, 8'h17, 1'b1, "R11 start held");

      // empty table after prepare
      do_prep(16'h3000, 8'd0, 16'h1234, 7'h0E);
      build_table(16'h3100, 8'd0, 8'h00, 0, 0);
      do_disp(16'h3100, 8'h00, 1'b0, "R7 zero count");

      // largest count
      do_prep(16'h4000, 8'd255, 16'h0F0F, 7'h30);
      build_table(16'h5000, 8'd255, 8'hA5, 1, 254);
      do_disp(16'h5000, 8'hA5, 1'b0, "R8 hit at 254");
      build_table(16'h5800, 8'd255, 8'hA5, 0, 0);
      do_disp(16'h5800, 8'hA5, 1'b0, "R8 miss 255");

      // constrained random
      for (int n = 0; n < 40; n++) begin
         logic [15:0] ppc, dpc;
         logic [7:0]  k, a;
         logic [6:0]  r;
         int mode, h;
         ppc  = 16'h0100 + 16'($urandom_range(0, 16'h6000));
         dpc  = 16'h8000 + 16'($urandom_range(0, 16'h6000));
         k    = 8'($urandom_range(0, 20));
         a    = 8'($urandom);
         r    = 7'($urandom_range(16'h0E, 16'h5B));
         mode = (k == 0) ? 0 : $urandom_range(0, 2);
         h    = (k == 0) ? 0 : $urandom_range(0, int'(k) - 1);
         do_prep(ppc, k, 16'($urandom), r);
         build_table(dpc, k, a, mode, h);
         do_disp(dpc, a, 1'b0, "R5 random");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule